// File: doc/BRIEF.md
# UART Loopback Self-Test Controller

This block is an 8-bit serial transmitter and receiver with a built-in self-test engine around them. In normal mode a host hands bytes to the transmitter through a valid/ready handshake and reads received bytes, with their error flags, from a holding register that stays valid until the host acknowledges it. The serial line and the host bytes reach the UART halves unchanged.

With `test_mode` high, a one-cycle `test_start` pulse starts a self-test. A maximal-length 8-bit LFSR produces 255 bytes. Each byte is framed by the transmitter, and the serial line is turned back inside the block to the receiver. Every received byte is folded into an 8-bit MISR. When the last byte has been folded in, the signature leaves the block one bit per clock on the ordinary serial output pin. A marker pulse flags the first bit. After that, a done flag rises, together with a pass flag that compares the signature against a constant. The block computes this constant at elaboration from the seed and the byte count.

Top module: `uart_bist_top`

## Requirements
- R1: A transmitted frame is a low start bit, then 8 data bits least significant bit first, then an even parity bit (the XOR of the data bits), then a high stop bit. Each bit lasts BIT_CLKS clocks (default 16).
- R2: In normal mode, `host_tx_ready` is high exactly when the transmitter is idle. While the transmitter is idle, `serial_out` is high. A byte is taken on a clock edge where `host_tx_valid` and `host_tx_ready` are both high.
- R3: In normal mode, a well-formed frame on `serial_in` appears on `rx_data` with `rx_valid` high. The receiver samples each bit at mid-bit. `rx_valid` stays high until a cycle with `rx_ack` high clears it.
- R4: `rx_parity_err` is high for a received frame whose parity bit makes the count of ones in data plus parity odd.
- R5: `rx_frame_err` is high for a received frame whose stop bit is sampled low.
- R6: `rx_break` is high for a received frame whose data, parity and stop bits are all low. `rx_frame_err` is high for such a frame as well.
- R7: If a frame completes while `rx_valid` is still high and not acknowledged, `rx_overrun` goes high and `rx_data` takes the newer byte. `rx_ack` clears `rx_overrun`.
- R8: In test mode, `host_tx_ready` and `rx_valid` stay low and `serial_in` has no effect on the result.
- R9: A self-test sends 255 bytes. The first byte is the seed (default 8'h5A). Each later byte is the previous byte shifted left by one, with new bit 0 = b7^b5^b4^b3. The MISR starts at zero. For each received byte d it becomes {m[6:0], m[7]^m[5]^m[4]^m[3]} XOR d.
- R10: After the last byte, the signature appears on `serial_out` most significant bit first, one bit per clock, for 8 clocks. `sig_frame` is high only during the first of those clocks.
- R11: `test_done` rises on the clock after the last signature bit. `test_pass` is high only when `test_done` is high and the signature equals the constant. Both stay unchanged until the next `test_start` or until test mode is left, and both read zero in normal mode.
- R12: A second `test_start` clears the done flag and the MISR and runs a fresh test, which gives the same signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Selects self-test (1) or normal operation (0) |
| test_start | input | 1 | One-cycle pulse that begins a self-test |
| host_tx_data | input | 8 | Byte to transmit |
| host_tx_valid | input | 1 | Host offers a byte |
| host_tx_ready | output | 1 | Transmitter can accept a byte |
| rx_ack | input | 1 | Host consumed the received byte |
| serial_in | input | 1 | External serial receive line |
| serial_out | output | 1 | Serial transmit line; carries the signature at test end |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte waiting for acknowledgement |
| rx_parity_err | output | 1 | Parity mismatch in the held frame |
| rx_frame_err | output | 1 | Stop bit low in the held frame |
| rx_break | output | 1 | Held frame was all zeros including stop |
| rx_overrun | output | 1 | A frame arrived before the previous was acknowledged |
| sig_frame | output | 1 | Marks the first signature bit |
| test_done | output | 1 | Self-test complete |
| test_pass | output | 1 | Signature matched the constant |

## Verification
The bench runs the full 255-byte self-test while it toggles `serial_in` at random. A design that leaked the external line into the loopback would then produce a wrong signature. It compares the eight signature bits, in order, with its own LFSR/MISR model. A reversed shift direction, a wrong tap or a missed first byte would show there as a mismatch. It times `test_done` against the last bit and reruns the test to catch a MISR that is not cleared. On the receive side it bit-bangs frames with flipped parity, a low stop bit, an all-zero break and two frames left unacknowledged. Each flag must then rise alone, and the newer byte must win.

// File: rtl/uart_bist_pkg.sv
package uart_bist_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    typedef enum logic [2:0] {
        BS_IDLE, BS_SEND, BS_WAIT, BS_SHIFT, BS_DONE
    } bist_state_e;

    // x^8+x^6+x^5+x^4+1, left shift, feedback into bit 0
    function automatic logic [BYTE_W-1:0] prpg_next(input logic [BYTE_W-1:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    function automatic logic [BYTE_W-1:0] sig_fold(input logic [BYTE_W-1:0] m,
                                                   input logic [BYTE_W-1:0] din);
        return {m[6:0], m[7] ^ m[5] ^ m[4] ^ m[3]} ^ din;
    endfunction

    function automatic logic [BYTE_W-1:0] golden_sig(input logic [BYTE_W-1:0] seed,
                                                     input int count);
        logic [BYTE_W-1:0] l;
        logic [BYTE_W-1:0] m;
        l = seed;
        m = '0;
        for (int i = 0; i < count; i++) begin
            m = sig_fold(m, l);
            l = prpg_next(l);
        end
        return m;
    endfunction

endpackage

// File: rtl/uart_bist_tx.sv
module uart_bist_tx #(
    parameter int BIT_CLKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    output logic       line,
    output logic       idle
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);
    localparam int FRAME_BITS = 11;

    typedef struct packed {
        logic                  busy;
        logic [FRAME_BITS-1:0] sr;
        logic [CW-1:0]         cnt;
        logic [3:0]            nbit;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sr   = {1'b1, ^byte_in, byte_in, 1'b0};
                d.cnt  = '0;
                d.nbit = '0;
            end
        end else if (q.cnt == LAST) begin
            d.cnt = '0;
            d.sr  = {1'b1, q.sr[FRAME_BITS-1:1]};
            if (q.nbit == 4'(FRAME_BITS - 1)) begin
                d.busy = 1'b0;
            end else begin
                d.nbit = q.nbit + 1'b1;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, sr: '1, cnt: '0, nbit: '0};
        end else begin
            q <= d;
        end
    end

    assign line = q.busy ? q.sr[0] : 1'b1;
    assign idle = !q.busy;

endmodule

// File: rtl/uart_bist_rx.sv
module uart_bist_rx
    import uart_bist_pkg::*;
#(
    parameter int BIT_CLKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       ack,
    output logic [7:0] data,
    output logic       valid,
    output logic       done,
    output logic       perr,
    output logic       ferr,
    output logic       brk,
    output logic       ovr
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);
    localparam logic [CW-1:0] HALF = CW'(BIT_CLKS / 2 - 1);

    typedef struct packed {
        rx_state_e   st;
        logic [1:0]  sync;
        logic        prev;
        logic [CW-1:0] cnt;
        logic [2:0]  idx;
        logic [7:0]  sh;
        logic        par;
        logic [7:0]  data;
        logic        valid;
        logic        done;
        logic        perr;
        logic        ferr;
        logic        brk;
        logic        ovr;
    } rx_s;

    rx_s  q, d;
    logic ln;

    assign ln = q.sync[1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], line_in};
        d.prev = ln;
        d.done = 1'b0;
        if (ack) begin
            d.valid = 1'b0;
            d.ovr   = 1'b0;
        end
        unique case (q.st)
            RX_IDLE: begin
                if (q.prev && !ln) begin
                    d.st  = RX_START;
                    d.cnt = '0;
                end
            end
            RX_START: begin
                if (q.cnt == HALF) begin
                    d.cnt = '0;
                    d.idx = '0;
                    d.st  = ln ? RX_IDLE : RX_DATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (q.cnt == LAST) begin
                    d.cnt = '0;
                    d.sh  = {ln, q.sh[7:1]};
                    d.idx = q.idx + 1'b1;
                    if (q.idx == 3'd7) d.st = RX_PAR;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_PAR: begin
                if (q.cnt == LAST) begin
                    d.cnt = '0;
                    d.par = ln;
                    d.st  = RX_STOP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (q.cnt == LAST) begin
                    d.cnt   = '0;
                    d.data  = q.sh;
                    d.perr  = ^{q.sh, q.par};
                    d.ferr  = !ln;
                    d.brk   = (q.sh == 8'h00) && !q.par && !ln;
                    d.ovr   = q.valid && !ack;
                    d.valid = 1'b1;
                    d.done  = 1'b1;
                    d.st    = RX_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, sync: 2'b11, prev: 1'b1, cnt: '0, idx: '0,
                   sh: '0, par: 1'b0, data: '0, valid: 1'b0, done: 1'b0,
                   perr: 1'b0, ferr: 1'b0, brk: 1'b0, ovr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign data  = q.data;
    assign valid = q.valid;
    assign done  = q.done;
    assign perr  = q.perr;
    assign ferr  = q.ferr;
    assign brk   = q.brk;
    assign ovr   = q.ovr;

endmodule

// File: rtl/uart_bist_engine.sv
module uart_bist_engine
    import uart_bist_pkg::*;
#(
    parameter int          NUM_BYTES = 255,
    parameter logic [7:0]  SEED      = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_mode,
    input  logic       test_start,
    input  logic       tx_idle,
    input  logic       rx_done,
    input  logic [7:0] rx_byte,
    output logic       tx_go,
    output logic [7:0] tx_byte,
    output logic       shifting,
    output logic       sig_bit,
    output logic       sig_first,
    output logic       done,
    output logic       pass,
    output logic [7:0] lfsr_mon
);
    localparam int NW = $clog2(NUM_BYTES + 1);
    localparam logic [NW-1:0] LAST_IDX = NW'(NUM_BYTES - 1);
    localparam logic [7:0] GOLD = golden_sig(SEED, NUM_BYTES);

    typedef struct packed {
        bist_state_e st;
        logic [7:0]  lfsr;
        logic [7:0]  misr;
        logic [NW-1:0] cnt;
        logic [7:0]  sh;
        logic [2:0]  shcnt;
        logic        done;
        logic        pass;
    } eng_s;

    eng_s q, d;

    always_comb begin
        d         = q;
        tx_go     = 1'b0;
        if (!test_mode) begin
            d.st   = BS_IDLE;
            d.done = 1'b0;
            d.pass = 1'b0;
        end else if (test_start) begin
            d.st   = BS_SEND;
            d.lfsr = SEED;
            d.misr = '0;
            d.cnt  = '0;
            d.done = 1'b0;
            d.pass = 1'b0;
        end else begin
            unique case (q.st)
                BS_SEND: begin
                    if (tx_idle) begin
                        tx_go  = 1'b1;
                        d.lfsr = prpg_next(q.lfsr);
                        d.st   = BS_WAIT;
                    end
                end
                BS_WAIT: begin
                    if (rx_done) begin
                        d.misr = sig_fold(q.misr, rx_byte);
                        if (q.cnt == LAST_IDX) begin
                            d.sh    = sig_fold(q.misr, rx_byte);
                            d.shcnt = '0;
                            d.st    = BS_SHIFT;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                            d.st  = BS_SEND;
                        end
                    end
                end
                BS_SHIFT: begin
                    d.sh    = {q.sh[6:0], 1'b0};
                    d.shcnt = q.shcnt + 1'b1;
                    if (q.shcnt == 3'd7) begin
                        d.st   = BS_DONE;
                        d.done = 1'b1;
                        d.pass = (q.misr == GOLD);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: BS_IDLE, lfsr: SEED, misr: '0, cnt: '0, sh: '0,
                   shcnt: '0, done: 1'b0, pass: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tx_byte   = q.lfsr;
    assign shifting  = (q.st == BS_SHIFT);
    assign sig_bit   = q.sh[7];
    assign sig_first = (q.st == BS_SHIFT) && (q.shcnt == 3'd0);
    assign done      = q.done;
    assign pass      = q.pass;
    assign lfsr_mon  = q.lfsr;

endmodule

// File: rtl/uart_bist_top.sv
module uart_bist_top #(
    parameter int          BIT_CLKS  = 16,
    parameter int          NUM_BYTES = 255,
    parameter logic [7:0]  SEED      = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_mode,
    input  logic       test_start,
    input  logic [7:0] host_tx_data,
    input  logic       host_tx_valid,
    output logic       host_tx_ready,
    input  logic       rx_ack,
    input  logic       serial_in,
    output logic       serial_out,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_parity_err,
    output logic       rx_frame_err,
    output logic       rx_break,
    output logic       rx_overrun,
    output logic       sig_frame,
    output logic       test_done,
    output logic       test_pass
);
    logic       tx_line, tx_idle, tx_start;
    logic [7:0] tx_byte;
    logic       rx_line, rx_done, rx_hold_valid, rx_ack_int;
    logic       eng_go, eng_shift, eng_bit;
    logic [7:0] eng_byte;
    logic [7:0] lfsr_mon;

    assign tx_start      = test_mode ? eng_go : (host_tx_valid && tx_idle);
    assign tx_byte       = test_mode ? eng_byte : host_tx_data;
    assign host_tx_ready = tx_idle && !test_mode;
    assign rx_line       = test_mode ? tx_line : serial_in;
    assign rx_ack_int    = rx_ack || test_mode;
    assign rx_valid      = rx_hold_valid && !test_mode;
    assign serial_out    = test_mode ? (eng_shift ? eng_bit : 1'b1) : tx_line;

    uart_bist_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .byte_in(tx_byte),
        .line(tx_line), .idle(tx_idle)
    );

    uart_bist_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
        .clk(clk), .rst_n(rst_n), .line_in(rx_line), .ack(rx_ack_int),
        .data(rx_data), .valid(rx_hold_valid), .done(rx_done),
        .perr(rx_parity_err), .ferr(rx_frame_err), .brk(rx_break),
        .ovr(rx_overrun)
    );

    uart_bist_engine #(.NUM_BYTES(NUM_BYTES), .SEED(SEED)) u_eng (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .test_start(test_start),
        .tx_idle(tx_idle), .rx_done(rx_done), .rx_byte(rx_data),
        .tx_go(eng_go), .tx_byte(eng_byte), .shifting(eng_shift),
        .sig_bit(eng_bit), .sig_first(sig_frame), .done(test_done),
        .pass(test_pass), .lfsr_mon(lfsr_mon)
    );

endmodule

// File: rtl/uart_bist_chk.sv
module uart_bist_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       test_mode,
    input logic       test_start,
    input logic       host_tx_ready,
    input logic       rx_valid,
    input logic       serial_out,
    input logic       sig_frame,
    input logic       test_done,
    input logic       test_pass,
    input logic [7:0] lfsr_mon
);
    // R8
    tx_ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> !host_tx_ready);

    // R8
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> !rx_valid);

    // R2
    line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && host_tx_ready) |-> serial_out);

    // R10
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_frame |=> !sig_frame);

    // R10
    frame_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_frame |-> (test_mode && !test_done));

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_done && test_mode && !test_start) |=> test_done);

    // R11
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_pass |-> test_done);

    // R9
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_mon != 8'h00);

endmodule

bind uart_bist_top uart_bist_chk u_chk (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .test_start(test_start),
    .host_tx_ready(host_tx_ready), .rx_valid(rx_valid), .serial_out(serial_out),
    .sig_frame(sig_frame), .test_done(test_done), .test_pass(test_pass),
    .lfsr_mon(lfsr_mon)
);

// File: tb/uart_bist_top_test.sv
module uart_bist_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int BITC  = 16;
    localparam int NBYTE = 255;
    localparam logic [7:0] SEED = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_mode = 1'b0, test_start = 1'b0;
    logic [7:0] host_tx_data = '0;
    logic       host_tx_valid = 1'b0, rx_ack = 1'b0, serial_in = 1'b1;
    logic       host_tx_ready, serial_out, rx_valid, rx_parity_err, rx_frame_err;
    logic       rx_break, rx_overrun, sig_frame, test_done, test_pass;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_bist_top #(.BIT_CLKS(BITC), .NUM_BYTES(NBYTE), .SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .test_start(test_start),
        .host_tx_data(host_tx_data), .host_tx_valid(host_tx_valid),
        .host_tx_ready(host_tx_ready), .rx_ack(rx_ack), .serial_in(serial_in),
        .serial_out(serial_out), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_break(rx_break), .rx_overrun(rx_overrun), .sig_frame(sig_frame),
        .test_done(test_done), .test_pass(test_pass)
    );

    function automatic logic [7:0] m_lfsr(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    function automatic logic [7:0] m_misr(input logic [7:0] m, input logic [7:0] b);
        return {m[6:0], m[7] ^ m[5] ^ m[4] ^ m[3]} ^ b;
    endfunction

    function automatic logic [7:0] m_sig();
        logic [7:0] l = SEED;
        logic [7:0] m = 8'h00;
        for (int i = 0; i < NBYTE; i++) begin
            m = m_misr(m, l);
            l = m_lfsr(l);
        end
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // R1: send a byte through the host port and sample the line at mid-bit
    task automatic tx_byte_chk(input logic [7:0] b);
        logic [10:0] got;
        logic [10:0] exp;
        int wait_n = 0;
        exp = {1'b1, ^b, b, 1'b0};
        @(negedge clk);
        host_tx_data  = b;
        host_tx_valid = 1'b1;
        @(negedge clk);
        host_tx_valid = 1'b0;
        while (serial_out !== 1'b0 && wait_n < 40) begin
            @(negedge clk);
            wait_n++;
        end
        check("R2 ready low while sending", {31'd0, host_tx_ready}, 32'd0);
        repeat (BITC/2) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            got[i] = serial_out;
            if (i < 10) repeat (BITC) @(negedge clk);
        end
        check("R1 tx frame bits", {21'd0, got}, {21'd0, exp});
        repeat (BITC) @(negedge clk);
        check("R2 ready back after frame", {31'd0, host_tx_ready}, 32'd1);
    endtask

    task automatic drive_frame(input logic [7:0] b, input logic par, input logic stp);
        logic [10:0] f;
        f = {stp, par, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            serial_in = f[i];
            repeat (BITC - 1) @(negedge clk);
        end
        @(negedge clk);
        serial_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack_rx();
        @(negedge clk);
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
    endtask

    // Run one self-test; returns the captured signature bits
    task automatic run_test(output logic [7:0] sig);
        int n = 0;
        @(negedge clk);
        test_start = 1'b1;
        @(negedge clk);
        test_start = 1'b0;
        check("R12 done cleared by start", {31'd0, test_done}, 32'd0);
        while (sig_frame !== 1'b1 && n < 60000) begin
            serial_in = 1'($urandom);
            if (rx_valid !== 1'b0) check("R8 rx_valid quiet in test", 32'd1, 32'd0);
            @(negedge clk);
            n++;
        end
        serial_in = 1'b1;
        check("R10 sig_frame seen", {31'd0, sig_frame}, 32'd1);
        for (int i = 7; i >= 0; i--) begin
            sig[i] = serial_out;
            check("R11 done low during shift", {31'd0, test_done}, 32'd0);
            @(negedge clk);
            if (i == 7) check("R10 sig_frame one cycle", {31'd0, sig_frame}, 32'd0);
        end
        check("R11 done after last bit", {31'd0, test_done}, 32'd1);
        check("R11 pass", {31'd0, test_pass}, 32'd1);
        repeat (5) @(negedge clk);
        check("R11 done holds", {30'd0, test_done, test_pass}, 32'd3);
        check("R10 line idle after shift", {31'd0, serial_out}, 32'd1);
    endtask

    initial begin
        automatic logic [7:0] s1;
        automatic logic [7:0] s2;
        automatic logic [7:0] gold;
        void'($urandom(32'd1234));
        gold = m_sig();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R2 reset ready", {31'd0, host_tx_ready}, 32'd1);
        check("R2 reset line high", {31'd0, serial_out}, 32'd1);
        check("R3 reset rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R11 reset done/pass", {30'd0, test_done, test_pass}, 32'd0);

        // R1 transmit directed and random
        tx_byte_chk(8'h00);
        tx_byte_chk(8'hA7);
        for (int i = 0; i < 3; i++) tx_byte_chk(8'($urandom));

        // R3 receive good frames
        for (int i = 0; i < 4; i++) begin
            automatic logic [7:0] b = (i == 0) ? 8'h3C : 8'($urandom);
            drive_frame(b, ^b, 1'b1);
            check("R3 rx data", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, b});
            check("R3 no error flags",
                  {28'd0, rx_parity_err, rx_frame_err, rx_break, rx_overrun}, 32'd0);
            repeat (3) @(negedge clk);
            check("R3 valid held", {31'd0, rx_valid}, 32'd1);
            ack_rx();
            check("R3 ack clears", {31'd0, rx_valid}, 32'd0);
        end

        // R4 parity error
        drive_frame(8'h81, 1'b1, 1'b1);
        check("R4 parity err", {29'd0, rx_parity_err, rx_frame_err, rx_break}, 32'd4);
        ack_rx();
        // R5 framing error
        drive_frame(8'h5B, ^8'h5B, 1'b0);
        check("R5 frame err", {29'd0, rx_parity_err, rx_frame_err, rx_break}, 32'd2);
        ack_rx();
        // R6 break
        drive_frame(8'h00, 1'b0, 1'b0);
        check("R6 break", {29'd0, rx_parity_err, rx_frame_err, rx_break}, 32'd3);
        ack_rx();
        // R7 overrun
        drive_frame(8'h11, ^8'h11, 1'b1);
        check("R7 no overrun first", {31'd0, rx_overrun}, 32'd0);
        drive_frame(8'hE2, ^8'hE2, 1'b1);
        check("R7 overrun", {23'd0, rx_overrun, rx_data}, {23'd0, 1'b1, 8'hE2});
        ack_rx();
        check("R7 ack clears overrun", {30'd0, rx_overrun, rx_valid}, 32'd0);

        // R8..R12 self-test
        test_mode = 1'b1;
        @(negedge clk);
        check("R8 ready low in test", {31'd0, host_tx_ready}, 32'd0);
        host_tx_valid = 1'b1;
        host_tx_data  = 8'hFF;
        run_test(s1);
        host_tx_valid = 1'b0;
        check("R9 signature", {24'd0, s1}, {24'd0, gold});
        run_test(s2);
        check("R12 rerun signature", {24'd0, s2}, {24'd0, gold});
        test_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11 cleared outside test", {30'd0, test_done, test_pass}, 32'd0);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule